// File: doc/BRIEF.md
# Nonvolatile Row Programming Sequencer

This block runs the timed update of a small nonvolatile word array after the serial front end has decoded a write. It takes one request at a time. A request either programs one row with a 16-bit word or initialises the whole array. Every update runs as two timed phases. The first phase clears the affected bits to zero. The second phase sets the bits that must end up as one. For its whole duration the block raises `busy`, and the front end uses that flag to withhold acknowledges, so a master can poll for completion. One cycle after the second phase ends, `busy` falls and `done` pulses for a single cycle. Single-byte and two-byte writes both reach this block as a full word and take the same path.

The array is a register model of 32 rows by 16 bits. A combinational read port lets the front end load a row into its transfer buffer at any time. Phase timing comes from a prescaler of `TICK_DIV` clocks and a phase counter of `PROG_TICKS/2` ticks. Each phase therefore lasts `PHASE = (PROG_TICKS/2)*TICK_DIV` clocks. The defaults give 5 ms per phase at 125 MHz.

States:
- `S_IDLE` waits for work.
- `S_ERASE` runs the clearing phase.
- `S_WRITE` runs the setting phase.
- `S_DONE` lasts one cycle and can accept a new request.

Transitions:
- IDLE or DONE goes to ERASE when a valid non-idle request arrives.
- IDLE or DONE otherwise goes to IDLE.
- ERASE goes to WRITE when the phase timer expires.
- WRITE goes to DONE when the phase timer expires.

Top module: `eeprom_prog_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every row reads 0x0000. A reset in the middle of a cycle also returns the block to this state.
- R2: The block accepts a request when `req_valid` is 1, `busy` is 0 and `req_op` is one of the following: 2'b01 programs a row, 2'b10 fills the array with zeros, 2'b11 fills the array with ones. `busy` reads 1 in the first cycle after the accepting edge.
- R3: The clearing phase lasts exactly PHASE cycles. For a program request, the target row still holds its old value in the last clearing cycle and reads 0x0000 from the first cycle of the setting phase.
- R4: The setting phase lasts exactly PHASE cycles. Afterwards the target row equals the requested word.
- R5: `busy` stays 1 for exactly 2*PHASE cycles. In the next cycle `busy` is 0 and `done` is 1. `done` is 0 again one cycle later.
- R6: A request presented while `busy` is 1 has no effect. It does not change the running operation's row, data or timing, and it is not queued.
- R7: A fill-zeros request makes every row 0x0000 from the first setting-phase cycle onward, and the rows stay 0x0000 after completion.
- R8: A fill-ones request makes every row 0x0000 after the clearing phase and every row 0xFFFF after the setting phase.
- R9: A program request leaves every other row unchanged.
- R10: A request with `req_op` = 2'b00 is ignored. `busy` stays 0 and the array is unchanged.
- R11: `rd_data` always shows the row selected by `rd_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 none, 01 program row, 10 fill zeros, 11 fill ones |
| req_row | input | AW (5) | Target row for a program request |
| req_data | input | WIDTH (16) | Word to program |
| rd_row | input | AW (5) | Read row select |
| rd_data | output | WIDTH (16) | Contents of the selected row |
| busy | output | 1 | High while a cycle is in progress |
| done | output | 1 | One-cycle pulse at completion |

## Verification
The sequencer state is only visible through `busy`, `done` and the array contents. A wrong state or a wrong phase count therefore shows up as a `busy` edge or a `done` pulse that is off by a cycle or more. Each phase boundary is sampled one cycle before and one cycle after the point where it should occur.

A wrong array command shows up in the full 32-row dump that is compared at both phase boundaries. Such a fault appears at the end of the phase in which it happens, so it is caught within PHASE cycles.

A request that is wrongly latched during `busy` is caught in two ways: it changes the completed row, or it leaves `busy` high after `done`.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_FILL0 = 2'b10,
        OP_FILL1 = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ERASE,
        S_WRITE,
        S_DONE
    } state_e;

    typedef struct packed {
        logic clr_row;
        logic clr_all;
        logic set_row;
        logic set_all;
    } arr_cmd_t;

endpackage

// File: rtl/eeprom_prog_tick.sv
module eeprom_prog_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_direct
            logic unused_clear;
            assign unused_clear = clear;
            assign tick = run;
        end else begin : g_count
            localparam int DW = $clog2(DIV);
            logic [DW-1:0] pre_q;
            logic          wrap;

            assign wrap = (pre_q == DW'(DIV - 1));
            assign tick = run && wrap;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (clear) begin
                    pre_q <= '0;
                end else if (run) begin
                    pre_q <= wrap ? '0 : pre_q + 1'b1;
                end
            end

            // R3: the prescaler never holds a value beyond its divide range
            p_pre_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
                pre_q <= DW'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
    parameter int PHASE_TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic phase_end
);

    localparam int CW = $clog2(PHASE_TICKS + 1);

    logic [CW-1:0] cnt_q;

    assign phase_end = tick && (cnt_q == CW'(PHASE_TICKS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= phase_end ? '0 : cnt_q + 1'b1;
        end
    end

    // R4: the tick counter stays below the phase length
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(PHASE_TICKS));

endmodule

// File: rtl/eeprom_prog_array.sv
module eeprom_prog_array
    import eeprom_prog_pkg::*;
#(
    parameter int ROWS  = 32,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  arr_cmd_t         cmd,
    input  logic [AW-1:0]    row,
    input  logic [WIDTH-1:0] data,
    input  logic [AW-1:0]    rd_row,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [ROWS];

    generate
        for (genvar i = 0; i < ROWS; i++) begin : g_row
            logic hit;
            assign hit = (row == AW'(i));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[i] <= '0;
                end else if (cmd.clr_all || (cmd.clr_row && hit)) begin
                    mem[i] <= '0;
                end else if (cmd.set_all) begin
                    mem[i] <= '1;
                end else if (cmd.set_row && hit) begin
                    mem[i] <= mem[i] | data;
                end
            end
        end
    endgenerate

    assign rd_data = mem[rd_row];

    // R3: a row clear leaves the target at zero
    p_erase_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr_row |=> (mem[$past(row)] == '0));

    // R7: an array clear zeroes both end rows
    p_clr_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr_all |=> (mem[0] == '0 && mem[ROWS-1] == '0));

    // R8: an array set drives both end rows to all ones
    p_set_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.set_all |=> (mem[0] == '1 && mem[ROWS-1] == '1));

    // R9: at most one array command per cycle
    p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd));

endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
    import eeprom_prog_pkg::*;
#(
    parameter int AW    = 5,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    req_row,
    input  logic [WIDTH-1:0] req_data,
    input  logic             phase_end,
    output logic             busy,
    output logic             done,
    output logic             timer_clear,
    output logic             timer_run,
    output arr_cmd_t         arr_cmd,
    output logic [AW-1:0]    tgt_row,
    output logic [WIDTH-1:0] tgt_data
);

    state_e state_q, state_d;
    op_e    op_q;
    op_e    op_in;
    logic   accept;

    assign op_in  = op_e'(req_op);
    assign accept = req_valid && (op_in != OP_NONE) &&
                    ((state_q == S_IDLE) || (state_q == S_DONE));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE: state_d = accept ? S_ERASE : S_IDLE;
            S_ERASE:        state_d = phase_end ? S_WRITE : S_ERASE;
            S_WRITE:        state_d = phase_end ? S_DONE : S_WRITE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            op_q     <= OP_NONE;
            tgt_row  <= '0;
            tgt_data <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q     <= op_in;
                tgt_row  <= req_row;
                tgt_data <= req_data;
            end
        end
    end

    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        timer_clear = accept;
        arr_cmd     = '0;
        unique case (state_q)
            S_IDLE: ;
            S_DONE: done = 1'b1;
            S_ERASE: begin
                busy = 1'b1;
                if (phase_end) begin
                    timer_clear = 1'b1;
                    if (op_q == OP_PROG) arr_cmd.clr_row = 1'b1;
                    else                 arr_cmd.clr_all = 1'b1;
                end
            end
            S_WRITE: begin
                busy = 1'b1;
                if (phase_end) begin
                    if (op_q == OP_PROG)       arr_cmd.set_row = 1'b1;
                    else if (op_q == OP_FILL1) arr_cmd.set_all = 1'b1;
                end
            end
        endcase
        timer_run = busy;
    end

    // R3: a running phase only ends on a timer expiry
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !phase_end) |=> $stable(state_q));

    // R5: done lasts one cycle and follows the setting phase
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q == S_WRITE));

    // R6: requests during busy leave the latched operation untouched
    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(tgt_row) && $stable(tgt_data) && $stable(op_q)));

    // R10: an idle-code request never starts a cycle
    p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op == 2'b00) |=> !busy);

endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
    import eeprom_prog_pkg::*;
#(
    parameter int ROWS       = 32,
    parameter int WIDTH      = 16,
    parameter int TICK_DIV   = 125,
    parameter int PROG_TICKS = 10000,
    parameter int AW         = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    req_row,
    input  logic [WIDTH-1:0] req_data,
    input  logic [AW-1:0]    rd_row,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy,
    output logic             done
);

    localparam int PHASE_TICKS = PROG_TICKS / 2;

    logic             tick;
    logic             phase_end;
    logic             timer_clear;
    logic             timer_run;
    arr_cmd_t         arr_cmd;
    logic [AW-1:0]    tgt_row;
    logic [WIDTH-1:0] tgt_data;

    eeprom_prog_ctrl #(
        .AW    (AW),
        .WIDTH (WIDTH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_row     (req_row),
        .req_data    (req_data),
        .phase_end   (phase_end),
        .busy        (busy),
        .done        (done),
        .timer_clear (timer_clear),
        .timer_run   (timer_run),
        .arr_cmd     (arr_cmd),
        .tgt_row     (tgt_row),
        .tgt_data    (tgt_data)
    );

    eeprom_prog_tick #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .run   (timer_run),
        .tick  (tick)
    );

    eeprom_prog_timer #(
        .PHASE_TICKS (PHASE_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (timer_clear),
        .tick      (tick),
        .phase_end (phase_end)
    );

    eeprom_prog_array #(
        .ROWS  (ROWS),
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (arr_cmd),
        .row     (tgt_row),
        .data    (tgt_data),
        .rd_row  (rd_row),
        .rd_data (rd_data)
    );

endmodule

// File: tb/eeprom_prog_seq_tb.sv
`timescale 1ns/1ps
module eeprom_prog_seq_tb;

    localparam int ROWS       = 32;
    localparam int WIDTH      = 16;
    localparam int TICK_DIV   = 4;
    localparam int PROG_TICKS = 20;
    localparam int AW         = 5;
    localparam int PH         = (PROG_TICKS / 2) * TICK_DIV;
    localparam int NVEC       = 8;

    // {op, row, data}
    localparam logic [22:0] VECS [NVEC] = '{
        {2'b11, 5'd0,  16'h0000},
        {2'b01, 5'd0,  16'h1234},
        {2'b01, 5'd31, 16'hA5C3},
        {2'b01, 5'd7,  16'h00FF},
        {2'b01, 5'd7,  16'hFF00},
        {2'b01, 5'd16, 16'h0000},
        {2'b10, 5'd0,  16'hFFFF},
        {2'b01, 5'd12, 16'h8001}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = 2'b00;
    logic [AW-1:0]    req_row = '0;
    logic [WIDTH-1:0] req_data = '0;
    logic [AW-1:0]    rd_row = '0;
    logic [WIDTH-1:0] rd_data;
    logic             busy;
    logic             done;

    logic [WIDTH-1:0] exp_mem [ROWS];
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    eeprom_prog_seq #(
        .ROWS       (ROWS),
        .WIDTH      (WIDTH),
        .TICK_DIV   (TICK_DIV),
        .PROG_TICKS (PROG_TICKS)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_row   (req_row),
        .req_data  (req_data),
        .rd_row    (rd_row),
        .rd_data   (rd_data),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input logic eb, input logic ed);
        chk({req, " busy"}, {15'b0, busy}, {15'b0, eb});
        chk({req, " done"}, {15'b0, done}, {15'b0, ed});
    endtask

    // R11: walk the read port through every row within one half period
    task automatic chk_all(input string req);
        for (int r = 0; r < ROWS; r++) begin
            rd_row = AW'(r);
            #0.05;
            chk($sformatf("%s row %0d", req, r), rd_data, exp_mem[r]);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [4:0] row, input logic [15:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_row   = row;
        req_data  = data;
        @(negedge clk);
        req_valid = 1'b0;
        req_op    = 2'b00;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int r = 0; r < ROWS; r++) exp_mem[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R1 reset", 1'b0, 1'b0);
        chk_all("R1 reset contents");

        // Table-driven operations
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  op;
            logic [4:0]  row;
            logic [15:0] data;
            op   = VECS[v][22:21];
            row  = VECS[v][20:16];
            data = VECS[v][15:0];
            issue(op, row, data);                       // cycle 0
            chk_flags("R2 accepted", 1'b1, 1'b0);
            repeat (PH - 1) @(negedge clk);             // cycle PH-1
            chk_flags("R3 clearing phase", 1'b1, 1'b0);
            rd_row = row;
            #0.05;
            chk("R3 row not yet cleared", rd_data, exp_mem[row]);
            @(negedge clk);                             // cycle PH
            if (op == 2'b01) exp_mem[row] = '0;
            else for (int r = 0; r < ROWS; r++) exp_mem[r] = '0;
            chk_flags("R4 setting phase", 1'b1, 1'b0);
            chk_all("R3 R7 R8 R9 after clearing");
            repeat (PH - 1) @(negedge clk);             // cycle 2PH-1
            chk_flags("R5 last busy cycle", 1'b1, 1'b0);
            @(negedge clk);                             // cycle 2PH
            if (op == 2'b01) exp_mem[row] = data;
            else if (op == 2'b11) for (int r = 0; r < ROWS; r++) exp_mem[r] = '1;
            chk_flags("R5 completion", 1'b0, 1'b1);
            chk_all("R4 R7 R8 R9 final contents");
            @(negedge clk);
            chk_flags("R5 done ends", 1'b0, 1'b0);
        end

        // R6: a request during busy is neither applied nor queued
        issue(2'b01, 5'd5, 16'h0F0F);
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_op = 2'b11; req_row = 5'd9; req_data = 16'h2222;
        @(negedge clk);                                 // cycle 6
        req_valid = 1'b0; req_op = 2'b00;
        repeat (2 * PH - 7) @(negedge clk);             // cycle 2PH-1
        chk_flags("R6 timing kept", 1'b1, 1'b0);
        @(negedge clk);
        exp_mem[5] = 16'h0F0F;
        chk_flags("R6 completion", 1'b0, 1'b1);
        chk_all("R6 contents");
        repeat (3) @(negedge clk);
        chk_flags("R6 not queued", 1'b0, 1'b0);

        // R10: idle-code request
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_row = 5'd2; req_data = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        chk_flags("R10 ignored", 1'b0, 1'b0);
        repeat (PH) @(negedge clk);
        chk_flags("R10 still idle", 1'b0, 1'b0);
        chk_all("R10 contents");

        // R1: reset in the middle of a cycle
        issue(2'b11, 5'd0, 16'h0000);
        repeat (10) @(negedge clk);
        chk_flags("R2 fill started", 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < ROWS; r++) exp_mem[r] = '0;
        chk_flags("R1 mid-cycle reset", 1'b0, 1'b0);
        chk_all("R1 mid-cycle reset contents");
        repeat (PH) @(negedge clk);
        chk_flags("R1 stays idle", 1'b0, 1'b0);

        finish_run();
    end

endmodule